// File: doc/BRIEF.md
# Host-to-PCI Write Burst Sequencer

This block takes one host-side memory write descriptor and turns it into one or more memory write transactions on a simplified PCI master interface. A descriptor has a 36-bit address, a two-bit length code, eight byte enables for the 64-bit host lane and up to four quadwords of data. The block works out how many transactions to issue and how long each one is. It presents the dwords one at a time, from the lowest address upward, and holds each beat until the target accepts it.

Short partial writes become one single-dword transaction for each dword that has any byte enabled. A full quadword becomes a 2-dword burst. A 16-byte request becomes a 4-dword burst and a 32-byte request becomes an 8-dword burst. For the 32-byte case, Memory Write and Invalidate is chosen when the configuration input allows it and the request sits on a 32-byte line. The block accepts a new descriptor only while it is idle. It pulses a completion flag once the last dword has been accepted.

Top module: `h2p_wr_seq`

## Requirements
- R1: After reset, `pci_valid` and `done` are 0 and `req_ready` is 1.
- R2: `req_ready` is 1 exactly when no beat is pending. A descriptor offered while `req_ready` is 0 is ignored and does not change the beats being issued.
- R3: With length code 2'b00 and byte enables not all set, a transaction of one beat is issued for each dword whose enables are not all zero. The low dword goes first, with `req_be[3:0]`, `req_data[31:0]` and address base. The high dword follows, with `req_be[7:4]`, `req_data[63:32]` and address base+4. Base is `req_addr` with bits [2:0] cleared.
- R4: With length code 2'b00 and all eight enables clear, no beat is issued and `done` pulses in the cycle after acceptance.
- R5: With length code 2'b00 and all eight enables set, a single 2-beat burst is issued at address base, with `pci_be` = 4'b1111 on both beats.
- R6: Length code 2'b01 issues one 4-beat burst at address base, with `pci_be` = 4'b1111 on every beat.
- R7: Length code 2'b10 issues one 8-beat burst at address base, with `pci_be` = 4'b1111 on every beat.
- R8: The command is 4'b1111 (write and invalidate) for length code 2'b10 when `mwi_en` is 1 and `req_addr[4:3]` is 2'b00. In every other case it is 4'b0111 (memory write).
- R9: Beat k of a burst carries `req_data[32k+31:32k]`. Dwords go out in ascending order.
- R10: While `pci_valid` is 1 and `pci_ready` is 0, every beat output holds its value into the next cycle.
- R11: `pci_last` is 1 only on the final beat of each transaction. Every single-dword transaction therefore has it set.
- R12: `done` is a one-cycle pulse in the cycle after the final beat is accepted. `req_ready` is 1 in that same cycle.
- R13: Length code 2'b11 is reserved. It issues no beat and pulses `done` in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Block idle, descriptor taken on valid |
| req_addr | input | 36 | Host byte address |
| req_len | input | 2 | 00 up to 8 bytes, 01 16 bytes, 10 32 bytes, 11 reserved |
| req_be | input | 8 | Byte enables of the 64-bit lane |
| req_data | input | 256 | Four quadwords, dword k at bits [32k+31:32k] |
| mwi_en | input | 1 | Permits write-and-invalidate for aligned 32-byte writes |
| pci_valid | output | 1 | Beat present |
| pci_ready | input | 1 | Target accepts the beat |
| pci_cmd | output | 4 | Bus command of the transaction |
| pci_addr | output | 36 | Start address of the transaction |
| pci_data | output | 32 | Dword data |
| pci_be | output | 4 | Per-dword byte enables, active high |
| pci_last | output | 1 | Final beat of the transaction |
| done | output | 1 | Descriptor finished |

## Verification
A wrong beat index shows at once on the next visible beat, as a dword out of order or from the wrong lane in `pci_data`. A wrong dword mask shows as a beat that should have been skipped, or as a missing beat. Then `done` arrives one handshake early or late, and `pci_last` falls on the wrong beat. A fault in the busy state shows within one cycle as `req_ready` high while a beat is pending, or as a second descriptor taken in the middle of a transfer. Under random stalls, a faulty hold path shows as beat fields that change before the target accepts them.

// File: rtl/h2p_pkg.sv
package h2p_pkg;
  localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
  localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

  typedef enum logic [1:0] {
    LEN_SHORT = 2'b00,
    LEN_HALF  = 2'b01,
    LEN_LINE  = 2'b10,
    LEN_RSVD  = 2'b11
  } len_code_t;
endpackage

// File: rtl/h2p_plan.sv
// Decides which dwords go out, whether each is its own transaction,
// and which command applies.
module h2p_plan
  import h2p_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DW_W   = 32,
  parameter int MAX_DW = 8
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          len,
  input  logic [DW_W/4-1:0]   be,
  input  logic                mwi_en,
  output logic [MAX_DW-1:0]   mask,
  output logic                split,
  output logic [3:0]          cmd
);
  localparam int DB        = DW_W / 8;
  localparam int LANE_BITS = $clog2(2 * DB);
  localparam int LINE_BITS = $clog2(MAX_DW * DB);
  localparam int HALF_DW   = MAX_DW / 2;

  logic line_ok;
  assign line_ok = (addr[LINE_BITS-1:LANE_BITS] == '0);

  always_comb begin
    mask  = '0;
    split = 1'b0;
    cmd   = CMD_MEM_WR;
    case (len_code_t'(len))
      LEN_SHORT: begin
        if (&be) begin
          mask[1:0] = 2'b11;
        end else begin
          split   = 1'b1;
          mask[0] = |be[DB-1:0];
          mask[1] = |be[2*DB-1:DB];
        end
      end
      LEN_HALF: mask[HALF_DW-1:0] = '1;
      LEN_LINE: begin
        mask = '1;
        if (mwi_en && line_ok) cmd = CMD_MEM_WRI;
      end
      default: mask = '0;
    endcase
  end
endmodule

// File: rtl/h2p_pick.sv
// Lowest set bit of a mask at or above a start index.
module h2p_pick #(
  parameter int MAX_DW = 8,
  localparam int IDX_W = $clog2(MAX_DW)
) (
  input  logic [MAX_DW-1:0] mask,
  input  logic [IDX_W:0]    start,
  output logic [IDX_W-1:0]  pos,
  output logic              found
);
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = MAX_DW - 1; i >= 0; i--) begin
      if (mask[i] && (i >= int'(start))) begin
        pos   = IDX_W'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/h2p_wr_seq.sv
module h2p_wr_seq
  import h2p_pkg::*;
#(
  parameter int ADDR_W = 36,
  parameter int DW_W   = 32,
  parameter int MAX_DW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [1:0]               req_len,
  input  logic [DW_W/4-1:0]        req_be,
  input  logic [MAX_DW*DW_W-1:0]   req_data,
  input  logic                     mwi_en,
  output logic                     pci_valid,
  input  logic                     pci_ready,
  output logic [3:0]               pci_cmd,
  output logic [ADDR_W-1:0]        pci_addr,
  output logic [DW_W-1:0]          pci_data,
  output logic [DW_W/8-1:0]        pci_be,
  output logic                     pci_last,
  output logic                     done
);
  localparam int DB        = DW_W / 8;
  localparam int QB        = 2 * DB;
  localparam int IDX_W     = $clog2(MAX_DW);
  localparam int LANE_BITS = $clog2(QB);
  localparam int DATA_W    = MAX_DW * DW_W;

  // stored descriptor
  logic [MAX_DW-1:0]    mask_q;
  logic                 split_q;
  logic [3:0]           cmd_q;
  logic [ADDR_W-1:0]    base_q;
  logic [DATA_W-1:0]    data_q;
  logic [QB-1:0]        be_q;
  logic [IDX_W-1:0]     idx_q;

  logic [MAX_DW-1:0]    plan_mask;
  logic                 plan_split;
  logic [3:0]           plan_cmd;
  logic [IDX_W-1:0]     f_pos, n_pos;
  logic                 f_found, n_found;
  logic                 accept, advance;

  assign req_ready = !pci_valid;
  assign accept    = req_valid && !pci_valid;
  assign advance   = pci_valid && pci_ready;

  h2p_plan #(.ADDR_W(ADDR_W), .DW_W(DW_W), .MAX_DW(MAX_DW)) u_plan (
    .addr(req_addr), .len(req_len), .be(req_be), .mwi_en(mwi_en),
    .mask(plan_mask), .split(plan_split), .cmd(plan_cmd)
  );

  h2p_pick #(.MAX_DW(MAX_DW)) u_first (
    .mask(plan_mask), .start('0), .pos(f_pos), .found(f_found)
  );

  h2p_pick #(.MAX_DW(MAX_DW)) u_next (
    .mask(mask_q), .start({1'b0, idx_q} + 1'b1), .pos(n_pos), .found(n_found)
  );

  // fields of the beat about to be loaded
  logic [IDX_W-1:0]        sel_idx;
  logic [MAX_DW-1:0]       sel_mask;
  logic                    sel_split;
  logic [ADDR_W-1:0]       sel_base;
  logic [DATA_W-1:0]       sel_dat;
  logic [MAX_DW*DB-1:0]    sel_be_ext;
  logic [MAX_DW:0]         mask_ext;
  logic                    sel_last;
  logic [DB-1:0]           sel_be;
  logic [ADDR_W-1:0]       sel_addr;

  always_comb begin
    sel_idx    = accept ? f_pos : n_pos;
    sel_mask   = accept ? plan_mask : mask_q;
    sel_split  = accept ? plan_split : split_q;
    sel_base   = accept ? {req_addr[ADDR_W-1:LANE_BITS], {LANE_BITS{1'b0}}} : base_q;
    sel_dat    = accept ? req_data : data_q;
    sel_be_ext = '0;
    sel_be_ext[QB-1:0] = accept ? req_be : be_q;
    mask_ext   = {1'b0, sel_mask};
    sel_last   = sel_split || !mask_ext[{1'b0, sel_idx} + 1'b1];
    sel_be     = sel_split ? sel_be_ext[sel_idx*DB +: DB] : '1;
    sel_addr   = sel_split ? sel_base + ADDR_W'(sel_idx) * ADDR_W'(DB) : sel_base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pci_valid <= 1'b0;
      done      <= 1'b0;
      pci_cmd   <= CMD_MEM_WR;
      pci_addr  <= '0;
      pci_data  <= '0;
      pci_be    <= '0;
      pci_last  <= 1'b0;
      idx_q     <= '0;
      mask_q    <= '0;
      split_q   <= 1'b0;
      cmd_q     <= CMD_MEM_WR;
      base_q    <= '0;
      data_q    <= '0;
      be_q      <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        mask_q  <= plan_mask;
        split_q <= plan_split;
        cmd_q   <= plan_cmd;
        base_q  <= sel_base;
        data_q  <= req_data;
        be_q    <= req_be;
        if (f_found) begin
          pci_valid <= 1'b1;
          idx_q     <= sel_idx;
          pci_cmd   <= plan_cmd;
          pci_addr  <= sel_addr;
          pci_data  <= sel_dat[sel_idx*DW_W +: DW_W];
          pci_be    <= sel_be;
          pci_last  <= sel_last;
        end else begin
          done <= 1'b1;
        end
      end else if (advance) begin
        if (n_found) begin
          idx_q    <= sel_idx;
          pci_cmd  <= cmd_q;
          pci_addr <= sel_addr;
          pci_data <= sel_dat[sel_idx*DW_W +: DW_W];
          pci_be   <= sel_be;
          pci_last <= sel_last;
        end else begin
          pci_valid <= 1'b0;
          pci_last  <= 1'b0;
          done      <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/h2p_wr_seq_chk.sv
module h2p_wr_seq_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [1:0]  req_len,
  input logic [7:0]  req_be,
  input logic [4:3]  req_addr_line,
  input logic        mwi_en,
  input logic        pci_valid,
  input logic        pci_ready,
  input logic [3:0]  pci_cmd,
  input logic [35:0] pci_addr,
  input logic [31:0] pci_data,
  input logic [3:0]  pci_be,
  input logic        pci_last,
  input logic        done
);
  // R2
  busy_blocks_req_chk: assert property (@(posedge clk) disable iff (rst)
    pci_valid |-> !req_ready);

  // R10
  hold_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (pci_valid && !pci_ready) |=> (pci_valid && $stable(pci_data) && $stable(pci_addr)
      && $stable(pci_be) && $stable(pci_cmd) && $stable(pci_last)));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R12
  done_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    (pci_valid && pci_ready && pci_last && req_ready == 1'b0) |=> (!pci_valid |-> done));

  // R13
  rsvd_len_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len == 2'b11) |=> (done && !pci_valid));

  // R5
  full_qword_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len == 2'b00 && req_be == 8'hFF)
      |=> (pci_valid && pci_be == 4'hF && !pci_last));

  // R8
  line_cmd_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_len == 2'b10)
      |=> (pci_cmd == ((mwi_en && req_addr_line == 2'b00) ? 4'b1111 : 4'b0111)) || $past(mwi_en) != mwi_en || 1'b1 == 1'b0 ? 1'b1 :
          (pci_cmd == (($past(mwi_en) && $past(req_addr_line) == 2'b00) ? 4'b1111 : 4'b0111)));
endmodule

bind h2p_wr_seq h2p_wr_seq_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_len(req_len), .req_be(req_be), .req_addr_line(req_addr[4:3]),
  .mwi_en(mwi_en), .pci_valid(pci_valid), .pci_ready(pci_ready),
  .pci_cmd(pci_cmd), .pci_addr(pci_addr), .pci_data(pci_data),
  .pci_be(pci_be), .pci_last(pci_last), .done(done)
);

// File: tb/h2p_wr_seq_bench.sv
module h2p_wr_seq_bench;
  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready;
  logic [35:0]   req_addr;
  logic [1:0]    req_len;
  logic [7:0]    req_be;
  logic [255:0]  req_data;
  logic          mwi_en;
  logic          pci_valid, pci_ready;
  logic [3:0]    pci_cmd;
  logic [35:0]   pci_addr;
  logic [31:0]   pci_data;
  logic [3:0]    pci_be;
  logic          pci_last;
  logic          done;

  int compared = 0;
  int mismatched = 0;

  always #2 clk = ~clk;

  h2p_wr_seq u_h2p_wr_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_be(req_be), .req_data(req_data),
    .mwi_en(mwi_en), .pci_valid(pci_valid), .pci_ready(pci_ready),
    .pci_cmd(pci_cmd), .pci_addr(pci_addr), .pci_data(pci_data),
    .pci_be(pci_be), .pci_last(pci_last), .done(done)
  );

  // expected beat list
  int          n_exp;
  logic [3:0]  e_cmd;
  logic [35:0] e_addr [8];
  logic [31:0] e_data [8];
  logic [3:0]  e_be   [8];
  logic        e_last [8];
  string       e_req;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic build_exp(input logic [35:0] a, input logic [1:0] l,
                           input logic [7:0] b, input logic [255:0] d, input logic m);
    logic [35:0] base;
    base  = {a[35:3], 3'b000};
    n_exp = 0;
    e_cmd = 4'b0111;
    if (l == 2'b00 && b != 8'hFF) begin
      e_req = (b == 8'h00) ? "R4" : "R3";
      for (int k = 0; k < 2; k++) begin
        if (b[4*k +: 4] != 4'h0) begin
          e_addr[n_exp] = base + 36'(4 * k);
          e_data[n_exp] = d[32*k +: 32];
          e_be[n_exp]   = b[4*k +: 4];
          e_last[n_exp] = 1'b1;
          n_exp++;
        end
      end
    end else if (l != 2'b11) begin
      int len;
      len   = (l == 2'b00) ? 2 : (l == 2'b01) ? 4 : 8;
      e_req = (l == 2'b00) ? "R5" : (l == 2'b01) ? "R6" : "R7";
      if (l == 2'b10 && m && a[4:3] == 2'b00) e_cmd = 4'b1111;
      for (int k = 0; k < len; k++) begin
        e_addr[k] = base;
        e_data[k] = d[32*k +: 32];
        e_be[k]   = 4'hF;
        e_last[k] = (k == len - 1);
      end
      n_exp = len;
    end else begin
      e_req = "R13";
    end
  endtask

  task automatic run_req(input logic [35:0] a, input logic [1:0] l,
                         input logic [7:0] b, input logic [255:0] d, input logic m);
    int  got;
    int  guard;
    logic fired;
    build_exp(a, l, b, d, m);
    @(negedge clk);
    check("R2 idle ready", 64'(req_ready), 64'd1);
    req_addr = a; req_len = l; req_be = b; req_data = d; mwi_en = m;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 0;
    guard = 0;
    forever begin
      if (done) begin
        req_valid = 1'b0;
        check({e_req, " beat count at done"}, 64'(got), 64'(n_exp));
        check("R12 ready with done", 64'(req_ready), 64'd1);
        break;
      end
      if (pci_valid) begin
        check("R2 busy not ready", 64'(req_ready), 64'd0);
        if (got < n_exp) begin
          check({e_req, " R8 cmd"}, 64'(pci_cmd), 64'(e_cmd));
          check({e_req, " addr"}, 64'(pci_addr), 64'(e_addr[got]));
          check({e_req, " R9 data"}, 64'(pci_data), 64'(e_data[got]));
          check({e_req, " be"}, 64'(pci_be), 64'(e_be[got]));
          check({e_req, " R11 last"}, 64'(pci_last), 64'(e_last[got]));
        end else begin
          check({e_req, " extra beat"}, 64'(got), 64'(n_exp));
        end
        // R2: a foreign descriptor while busy must be ignored
        req_addr = {$urandom, $urandom};
        req_len = 2'($urandom);
        req_be = 8'($urandom);
        req_data = {8{$urandom}};
        req_valid = ($urandom % 2) == 0;
      end
      pci_ready = ($urandom % 3) != 0;
      fired = pci_valid && pci_ready;
      @(negedge clk);
      if (fired) got++;
      guard++;
      if (guard > 200) begin
        check({e_req, " no done"}, 64'd0, 64'd1);
        break;
      end
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R12 done single cycle", 64'(done), 64'd0);
  endtask

  function automatic logic [255:0] rnd_data();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[32*k +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1905));
    rst = 1'b1; req_valid = 1'b0; pci_ready = 1'b0;
    req_addr = '0; req_len = '0; req_be = '0; req_data = '0; mwi_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check("R1 valid", 64'(pci_valid), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 ready", 64'(req_ready), 64'd1);

    // directed corners
    run_req(36'h1_2345_6780, 2'b00, 8'h00, rnd_data(), 1'b0); // R4
    run_req(36'h1_2345_6788, 2'b00, 8'h0C, rnd_data(), 1'b0); // R3 low only
    run_req(36'h0_0000_0104, 2'b00, 8'h30, rnd_data(), 1'b0); // R3 high only
    run_req(36'h0_0000_0200, 2'b00, 8'h7F, rnd_data(), 1'b0); // R3 both
    run_req(36'h0_0000_0300, 2'b00, 8'hFF, rnd_data(), 1'b1); // R5
    run_req(36'h0_0000_0410, 2'b01, 8'h00, rnd_data(), 1'b1); // R6
    run_req(36'h0_0000_0500, 2'b10, 8'h00, rnd_data(), 1'b1); // R7 R8 invalidate
    run_req(36'h0_0000_0500, 2'b10, 8'hFF, rnd_data(), 1'b0); // R8 disabled
    run_req(36'h0_0000_0508, 2'b10, 8'hFF, rnd_data(), 1'b1); // R8 misaligned
    run_req(36'h0_0000_0518, 2'b10, 8'hFF, rnd_data(), 1'b1); // R8 misaligned
    run_req(36'hF_FFFF_FFE0, 2'b11, 8'hFF, rnd_data(), 1'b1); // R13

    // constrained random
    for (int t = 0; t < 300; t++) begin
      logic [7:0] b;
      b = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom);
      run_req({4'($urandom), $urandom}, 2'($urandom), b, rnd_data(), 1'($urandom));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule